// File: doc/BRIEF.md
# TDM Multichannel Lane Remapper

The remapper takes a time-division-multiplexed set of sample channels that arrives on one or more physical input lanes under a single valid strobe. It re-packs those channels onto a different number of output lanes. Each input lane delivers its share of the channels as one unbroken run of valid cycles per frame, followed by idle cycles. A frame is as long as the clock rate divided by the per-channel sample rate. Once a whole group has been captured, every output lane presents its own share of the channels in consecutive valid cycles, in ascending channel order.

With the default setting, 15 channels on a single input lane come out on 5 lanes of 3 channels each, in a 32-cycle frame. Other layouts follow from the parameters. One example is one channel per lane on every lane, which makes the group a single cycle. Another is two lanes of two channels each. The block also checks the input framing. A valid run that breaks before it is complete raises a sticky framing error, and the partial group is dropped. A group that completes less than one frame after the previous complete group raises a sticky overrun error.

The stream has no back-pressure in either direction, because the TDM timing is fixed by the frame. There is no ready signal. The input is taken on every cycle in which `in_valid` is high. The consumer must accept the output on every cycle in which `out_valid` is high. Let CH_IN = NUM_CH / IN_LANES and CH_OUT = NUM_CH / OUT_LANES. Both must divide evenly, and neither may exceed FRAME_LEN.

Top module: `tdm_lane_remap`

## Requirements
- R1: On the c-th valid cycle of a group (c counted from 0), input lane l (bits [l*DW +: DW]) carries channel l*CH_IN + c.
- R2: On the j-th valid output cycle of a group (j counted from 0), output lane k (bits [k*DW +: DW]) carries channel k*CH_OUT + j.
- R3: For each complete group, `out_valid` is high for exactly CH_OUT consecutive cycles. The first of these is the cycle right after the group's last valid input cycle.
- R4: While `out_valid` is low, `out_data` is all zeros.
- R5: Any number of idle cycles may come between groups without raising either error flag. This includes a spacing of exactly FRAME_LEN cycles between group completions.
- R6: If `in_valid` drops after at least one valid cycle of a group but before CH_IN of them have arrived, `err_framing` goes high on the next cycle. The partial group produces no output. The next valid cycle starts a fresh group.
- R7: If a group completes fewer than FRAME_LEN cycles after the previous complete group, `err_overrun` goes high on the next cycle. The late group is still presented on the output.
- R8: Both error flags stay high until reset.
- R9: A synchronous active-high `rst` clears the counters, capture slots, `out_valid`, `out_data` and both error flags by the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input strobe shared by all input lanes |
| in_data | input | IN_LANES*DW | Input lanes, lane l at [l*DW +: DW] |
| out_valid | output | 1 | Output strobe shared by all output lanes |
| out_data | output | OUT_LANES*DW | Output lanes, lane k at [k*DW +: DW] |
| err_framing | output | 1 | Sticky flag: a valid run broke off early |
| err_overrun | output | 1 | Sticky flag: groups completed closer together than one frame |

## Verification
A group's output is due in the cycle after its final valid input cycle and in the CH_OUT-1 cycles that follow. Each error flag is due in the cycle after the offending input cycle. The driver records the cycle number of each group's last valid input. For every expected output word it queues that number plus one plus the word's position. The monitor samples at the falling edge and compares both the data and the cycle number, so an early or late word fails even when its value is right. Flag checks are taken just after the rising edge that ends the offending cycle. Idle outputs are checked for zeros on every sampled cycle.

// File: rtl/tdm_remap_pkg.sv
package tdm_remap_pkg;

  typedef struct packed {
    logic framing;
    logic overrun;
  } tdm_err_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tdm_in_capture.sv
module tdm_in_capture
  import tdm_remap_pkg::*;
#(
  parameter int unsigned NUM_CH   = 15,
  parameter int unsigned IN_LANES = 1,
  parameter int unsigned DW       = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [IN_LANES*DW-1:0] in_data,
  output logic                   grp_done,
  output logic [NUM_CH*DW-1:0]   grp_data,
  output logic                   frm_break
);

  localparam int unsigned CH_IN = NUM_CH / IN_LANES;
  localparam int unsigned CW    = cnt_width(CH_IN);
  localparam logic [CW-1:0] LAST_POS = CW'(CH_IN - 1);

  logic [CW-1:0] pos;

  // Position inside the current valid run; any idle cycle returns it to zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (in_valid) begin
      pos <= (pos == LAST_POS) ? '0 : pos + CW'(1);
    end else begin
      pos <= '0;
    end
  end

  assign grp_done  = in_valid && (pos == LAST_POS);
  assign frm_break = !in_valid && (pos != '0);

  // One slot per channel; the cycle that completes a group is forwarded live.
  for (genvar l = 0; l < int'(IN_LANES); l++) begin : g_lane
    for (genvar c = 0; c < int'(CH_IN); c++) begin : g_slot
      localparam int unsigned IDX = l * CH_IN + c;
      logic [DW-1:0] slot;
      logic          hit;

      assign hit = in_valid && (pos == CW'(c));

      always_ff @(posedge clk) begin
        if (rst) begin
          slot <= '0;
        end else if (hit) begin
          slot <= in_data[l*DW +: DW];
        end
      end

      assign grp_data[IDX*DW +: DW] = hit ? in_data[l*DW +: DW] : slot;
    end
  end

endmodule

// File: rtl/tdm_frame_guard.sv
module tdm_frame_guard #(
  parameter int unsigned FRAME_LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic grp_done,
  output logic too_soon
);

  localparam int unsigned GW = $clog2(FRAME_LEN + 1);
  localparam logic [GW-1:0] FULL = GW'(FRAME_LEN);

  logic [GW-1:0] gap;

  // Cycles since the last completed group, saturating at one frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= FULL;
    end else if (grp_done) begin
      gap <= GW'(1);
    end else if (gap < FULL) begin
      gap <= gap + GW'(1);
    end
  end

  assign too_soon = grp_done && (gap < FULL);

endmodule

// File: rtl/tdm_out_drain.sv
module tdm_out_drain
  import tdm_remap_pkg::*;
#(
  parameter int unsigned NUM_CH    = 15,
  parameter int unsigned OUT_LANES = 5,
  parameter int unsigned DW        = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [NUM_CH*DW-1:0]    load_data,
  output logic                    out_valid,
  output logic [OUT_LANES*DW-1:0] out_data
);

  localparam int unsigned CH_OUT = NUM_CH / OUT_LANES;
  localparam int unsigned OCW    = cnt_width(CH_OUT);
  localparam logic [OCW-1:0] LAST_STEP = OCW'(CH_OUT - 1);

  logic [NUM_CH*DW-1:0] hold;
  logic [OCW-1:0]       step;
  logic                 active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= '0;
      step   <= '0;
      active <= 1'b0;
    end else if (load) begin
      hold   <= load_data;
      step   <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (step == LAST_STEP) begin
        active <= 1'b0;
        step   <= '0;
      end else begin
        step <= step + OCW'(1);
      end
    end
  end

  assign out_valid = active;

  for (genvar k = 0; k < int'(OUT_LANES); k++) begin : g_olane
    logic [DW-1:0] word;
    assign word = hold[(k * int'(CH_OUT) + int'(step)) * int'(DW) +: DW];
    assign out_data[k*DW +: DW] = active ? word : '0;
  end

endmodule

// File: rtl/tdm_lane_remap.sv
module tdm_lane_remap
  import tdm_remap_pkg::*;
#(
  parameter int unsigned NUM_CH    = 15,
  parameter int unsigned IN_LANES  = 1,
  parameter int unsigned OUT_LANES = 5,
  parameter int unsigned FRAME_LEN = 32,
  parameter int unsigned DW        = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [IN_LANES*DW-1:0]  in_data,
  output logic                    out_valid,
  output logic [OUT_LANES*DW-1:0] out_data,
  output logic                    err_framing,
  output logic                    err_overrun
);

  localparam int unsigned CH_IN  = NUM_CH / IN_LANES;
  localparam int unsigned CH_OUT = NUM_CH / OUT_LANES;

  if ((CH_IN * IN_LANES != NUM_CH) || (CH_OUT * OUT_LANES != NUM_CH)) begin : g_bad_split
    $error("channel count must divide evenly over both lane counts");
  end
  if ((CH_IN > FRAME_LEN) || (CH_OUT > FRAME_LEN)) begin : g_bad_frame
    $error("a lane cannot carry more channels than the frame has cycles");
  end

  logic                 grp_done;
  logic                 frm_break;
  logic                 too_soon;
  logic [NUM_CH*DW-1:0] grp_data;
  tdm_err_t             err_q;

  tdm_in_capture #(
    .NUM_CH  (NUM_CH),
    .IN_LANES(IN_LANES),
    .DW      (DW)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .grp_done (grp_done),
    .grp_data (grp_data),
    .frm_break(frm_break)
  );

  tdm_frame_guard #(
    .FRAME_LEN(FRAME_LEN)
  ) u_guard (
    .clk     (clk),
    .rst     (rst),
    .grp_done(grp_done),
    .too_soon(too_soon)
  );

  tdm_out_drain #(
    .NUM_CH   (NUM_CH),
    .OUT_LANES(OUT_LANES),
    .DW       (DW)
  ) u_drain (
    .clk      (clk),
    .rst      (rst),
    .load     (grp_done),
    .load_data(grp_data),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
    end else begin
      if (frm_break) err_q.framing <= 1'b1;
      if (too_soon)  err_q.overrun <= 1'b1;
    end
  end

  assign err_framing = err_q.framing;
  assign err_overrun = err_q.overrun;

endmodule

// File: rtl/tdm_lane_remap_check.sv
module tdm_lane_remap_check #(
  parameter int unsigned NUM_CH    = 15,
  parameter int unsigned IN_LANES  = 1,
  parameter int unsigned OUT_LANES = 5,
  parameter int unsigned FRAME_LEN = 32,
  parameter int unsigned DW        = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [IN_LANES*DW-1:0]  in_data,
  input logic                    out_valid,
  input logic [OUT_LANES*DW-1:0] out_data,
  input logic                    err_framing,
  input logic                    err_overrun
);

  localparam int CH_IN  = int'(NUM_CH / IN_LANES);
  localparam int CH_OUT = int'(NUM_CH / OUT_LANES);

  int orun;
  int ipos;

  always_ff @(posedge clk) begin
    if (rst) begin
      orun <= 0;
      ipos <= 0;
    end else begin
      orun <= out_valid ? orun + 1 : 0;
      if (in_valid) ipos <= (ipos == CH_IN - 1) ? 0 : ipos + 1;
      else          ipos <= 0;
    end
  end

  // R3: a run of output valids, once ended, was exactly CH_OUT long
  a_r3_run_length: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && orun != 0 && !err_overrun) |-> orun == CH_OUT);

  // R3: output begins only right after a valid input cycle
  a_r3_starts_after_input: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid));

  // R6: an interrupted valid run raises the framing flag
  a_r6_break_flagged: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && ipos != 0) |=> err_framing);

  // R8: flags hold until reset
  a_r8_framing_sticky: assert property (@(posedge clk) disable iff (rst)
    err_framing |=> err_framing);
  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    err_overrun |=> err_overrun);

  // R9: reset leaves outputs quiet
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !err_framing && !err_overrun));

  logic unused_ok;
  assign unused_ok = ^{in_data, out_data, FRAME_LEN};

endmodule

bind tdm_lane_remap tdm_lane_remap_check #(
  .NUM_CH   (NUM_CH),
  .IN_LANES (IN_LANES),
  .OUT_LANES(OUT_LANES),
  .FRAME_LEN(FRAME_LEN),
  .DW       (DW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .err_framing(err_framing),
  .err_overrun(err_overrun)
);

// File: tb/tdm_lane_remap_test.sv
module tdm_lane_remap_test;

  localparam int NUM_CH    = 15;
  localparam int IN_LANES  = 1;
  localparam int OUT_LANES = 5;
  localparam int FRAME_LEN = 32;
  localparam int DW        = 16;
  localparam int CH_IN     = NUM_CH / IN_LANES;
  localparam int CH_OUT    = NUM_CH / OUT_LANES;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                    rst;
  logic                    in_valid;
  logic [IN_LANES*DW-1:0]  in_data;
  logic                    out_valid;
  logic [OUT_LANES*DW-1:0] out_data;
  logic                    err_framing;
  logic                    err_overrun;

  tdm_lane_remap #(
    .NUM_CH(NUM_CH), .IN_LANES(IN_LANES), .OUT_LANES(OUT_LANES),
    .FRAME_LEN(FRAME_LEN), .DW(DW)
  ) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .err_framing(err_framing), .err_overrun(err_overrun)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [OUT_LANES*DW-1:0] exp_q[$];
  int                      due_q[$];

  function automatic logic [DW-1:0] chval(input int base, input int ch);
    return DW'((base << 8) | ch);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      in_valid = 1'b0;
      in_data  = '0;
    end
  endtask

  // Driver: R1 input layout; full groups queue R2 words with R3 due cycles.
  task automatic send_group(input int base, input int nvalid);
    int last;
    logic [OUT_LANES*DW-1:0] item;
    last = 0;
    for (int c = 0; c < nvalid; c++) begin
      tick();
      in_valid = 1'b1;
      for (int l = 0; l < IN_LANES; l++) in_data[l*DW +: DW] = chval(base, l*CH_IN + c);
      last = cyc;
    end
    if (nvalid == CH_IN) begin
      for (int j = 0; j < CH_OUT; j++) begin
        for (int k = 0; k < OUT_LANES; k++) item[k*DW +: DW] = chval(base, k*CH_OUT + j);
        exp_q.push_back(item);
        due_q.push_back(last + 1 + j);
      end
    end
  endtask

  // Monitor
  logic [OUT_LANES*DW-1:0] m_exp;
  int                      m_due;
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected output word", out_data, 0);
        end else begin
          m_exp = exp_q.pop_front();
          m_due = due_q.pop_front();
          chk(out_data == m_exp, "R1 R2 lane data", out_data, m_exp);
          chk(cyc == m_due, "R3 output cycle", cyc, m_due);
        end
      end else begin
        chk(out_data == '0, "R4 idle zeros", out_data, 0);
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    repeat (3) tick();
    rst = 1'b0;
    chk(!out_valid && !err_framing && !err_overrun, "R9 reset state",
        {out_valid, err_framing, err_overrun}, 0);

    // groups spaced exactly one frame apart, then a long gap
    send_group(1, CH_IN); idle(FRAME_LEN - CH_IN);
    send_group(2, CH_IN); idle(40);
    send_group(3, CH_IN); idle(FRAME_LEN - CH_IN);
    chk(!err_framing && !err_overrun, "R5 no flag with idle gaps",
        {err_framing, err_overrun}, 0);

    // broken run
    send_group(4, 7);
    idle(1);
    tick();
    chk(err_framing, "R6 framing flag", err_framing, 1);
    idle(30);
    send_group(5, CH_IN); idle(20);
    chk(exp_q.size() == 0, "R6 resync group delivered", exp_q.size(), 0);
    chk(!err_overrun, "R6 no overrun after resync", err_overrun, 0);
    chk(err_framing, "R8 framing sticky", err_framing, 1);

    // reset clears flags
    tick(); rst = 1'b1;
    tick(); rst = 1'b0;
    chk(!err_framing && !err_overrun && !out_valid, "R9 reset clears",
        {out_valid, err_framing, err_overrun}, 0);
    idle(5);

    // groups too close together
    send_group(6, CH_IN); idle(2);
    send_group(7, CH_IN);
    idle(1);
    chk(err_overrun, "R7 overrun flag", err_overrun, 1);
    chk(!err_framing, "R7 no framing flag", err_framing, 0);
    idle(40);
    chk(exp_q.size() == 0, "R7 late group still output", exp_q.size(), 0);
    chk(err_overrun, "R8 overrun sticky", err_overrun, 1);

    summary();
  end

endmodule